// File: doc/BRIEF.md
# Storage DMA Transfer Sequencer

This block steers one drive-to-memory DMA transfer on behalf of a storage controller whose data moves through a descriptor-driven DMA channel. A start command loads the total byte count for the transfer, clears the running byte index, raises an active flag and kicks the channel. Each chunk the channel then delivers is classified. It may be parked because the transfer is not active yet. It may close the transfer. It may end only the current chunk, or it may be copied straight from the drive's internal buffer. Otherwise it becomes a read, write or trim request to a downstream alignment adapter, carrying a byte offset into the medium.

Disk-style and optical-style drives differ in three ways: how the total size is formed, how the offset is scaled, and which status they report at the end. An optical transfer whose block address is all ones carries non-block packet data. That data is copied directly rather than requested from the medium. Every path that closes a chunk or a transfer emits a single end pulse to the channel, which also marks the drive inactive. Statistics pulses accompany those ends for the commands that are counted.

Top module: `dma_xfer_seq`

## Requirements
- R1: A start pulse loads the index with 0 and the remaining size with sector count × 512 (disk, `is_optical_i`=0) or the packet size (optical). It sets `active_o`, resets `status_o` to 0, and pulses `kick_o` for one cycle. All of these are visible in the cycle after the start edge.
- R2: A chunk that arrives while `active_o` is low produces only a one-cycle `park_o` pulse. No request, copy, interrupt, end pulse or status change follows.
- R3: When an event is evaluated while the remaining size is zero or negative, the transfer completes. `status_o` becomes 1 (ready and seek complete) for a disk or 2 (packet success) for an optical drive. `irq_o` and `dma_end_o` pulse and `active_o` drops.
- R4: A chunk of length 0 that arrives while the remaining size is positive pulses only `dma_end_o`. `active_o` and `status_o` are unchanged and there is no `irq_o`.
- R5: A disk chunk of nonzero length issues a one-cycle `req_valid_o`. The request carries offset = current sector × 512 + index, length = chunk length, and command = `cmd_i` (0 read, 1 write, 2 trim). The index then grows by the length and the remaining size shrinks by it.
- R6: An optical chunk issues a request with offset = block address × 2048 + index and command 0 (read).
- R7: For an optical drive with an all-ones block address, a chunk pulses `copy_valid_o` with `copy_len_o` = min(remaining, chunk length). It then completes as in R3 with status 2.
- R8: An error result for an outstanding request ends the transfer. `status_o` becomes 3 for a disk or 4 for an optical drive, `irq_o`, `dma_end_o` and `acct_fail_o` pulse, and `active_o` drops.
- R9: A successful result for an outstanding request ends the chunk. It completes the transfer (R3) if the remaining size is then zero or below; otherwise only `dma_end_o` pulses.
- R10: Each successful end pulse comes with `acct_ok_o` for optical transfers and for disk read or write, never for disk trim. `acct_ok_o` and `acct_fail_o` never pulse together.
- R11: While a request is outstanding, `chunk_valid_i` is ignored: no request, park or end pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a new transfer |
| is_optical_i | input | 1 | Drive type at start: 1 optical, 0 disk |
| sector_cnt_i | input | SCNT_W | Disk sector count |
| packet_size_i | input | SIZE_W | Optical packet transfer size in bytes |
| cur_sector_i | input | SEC_W | Disk current sector |
| lba_i | input | LBA_W | Optical block address; all ones means non-block data |
| cmd_i | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| chunk_valid_i | input | 1 | Channel delivers a chunk |
| chunk_len_i | input | LEN_W | Chunk length in bytes |
| req_done_i | input | 1 | Outstanding request finished without error |
| req_err_i | input | 1 | Outstanding request finished with error |
| kick_o | output | 1 | Kick pulse to the channel |
| active_o | output | 1 | Transfer active flag |
| park_o | output | 1 | Chunk left unprocessed, waiting for restart |
| req_valid_o | output | 1 | Request to the alignment adapter |
| req_cmd_o | output | 2 | Request command |
| req_offset_o | output | OFF_W | Request byte offset in the medium |
| req_len_o | output | LEN_W | Request length in bytes |
| copy_valid_o | output | 1 | Direct buffer copy to memory |
| copy_len_o | output | LEN_W | Direct copy length |
| status_o | output | 3 | Drive status code (0 none, 1..4 as in R3, R8) |
| irq_o | output | 1 | Interrupt pulse |
| dma_end_o | output | 1 | End of DMA pulse, drive inactive |
| acct_ok_o | output | 1 | Statistics pulse, success |
| acct_fail_o | output | 1 | Statistics pulse, failure |

## Verification
The bench sweeps disk transfers over all three commands, several sector counts, current sectors and chunk sizes. It also sweeps optical transfers over several block addresses and packet sizes, and uses chunk sizes that overshoot the last chunk so the remaining size goes negative. A design that tested for zero remaining instead of zero-or-below would then hang with the transfer active. A design that scaled the optical address by 512, or left out the index, would put every chunk after the first at the wrong offset. The bench also targets the all-ones address copy with both orderings of remaining and chunk length, a zero-length chunk that must not finish the transfer, trim transfers that must stay out of the statistics, and chunks sent while a request is outstanding or after the transfer closed. Those must park or be ignored rather than issue a second request.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int unsigned DISK_SECTOR_SHIFT = 9;
    localparam int unsigned PKT_BLOCK_SHIFT   = 11;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_TRIM  = 2'd2,
        CMD_RSVD  = 2'd3
    } xfer_cmd_e;

    typedef enum logic [2:0] {
        ST_NONE       = 3'd0,
        ST_DISK_READY = 3'd1,
        ST_PKT_OK     = 3'd2,
        ST_DMA_ERR    = 3'd3,
        ST_PKT_IOERR  = 3'd4
    } drv_status_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        ACT_NONE      = 3'd0,
        ACT_PARK      = 3'd1,
        ACT_ERROR     = 3'd2,
        ACT_COMPLETE  = 3'd3,
        ACT_CHUNK_END = 3'd4,
        ACT_COPY      = 3'd5,
        ACT_ISSUE     = 3'd6
    } action_e;

endpackage

// File: rtl/dma_xfer_scale.sv
module dma_xfer_scale #(
    parameter int IN_W  = 24,
    parameter int SHIFT = 9,
    parameter int OUT_W = 34
) (
    input  logic [IN_W-1:0]  base_i,
    output logic [OUT_W-1:0] scaled_o
);
    assign scaled_o = OUT_W'(base_i) << SHIFT;
endmodule

// File: rtl/dma_xfer_offset.sv
module dma_xfer_offset
    import dma_xfer_pkg::*;
#(
    parameter int SEC_W = 24,
    parameter int LBA_W = 20,
    parameter int IDX_W = 21,
    parameter int OFF_W = 34
) (
    input  logic             optical_i,
    input  logic [SEC_W-1:0] cur_sector_i,
    input  logic [LBA_W-1:0] lba_i,
    input  logic [IDX_W-1:0] index_i,
    output logic [OFF_W-1:0] offset_o,
    output logic             raw_data_o
);
    logic [OFF_W-1:0] disk_base;
    logic [OFF_W-1:0] pkt_base;

    dma_xfer_scale #(
        .IN_W (SEC_W),
        .SHIFT(DISK_SECTOR_SHIFT),
        .OUT_W(OFF_W)
    ) u_disk_scale (
        .base_i  (cur_sector_i),
        .scaled_o(disk_base)
    );

    dma_xfer_scale #(
        .IN_W (LBA_W),
        .SHIFT(PKT_BLOCK_SHIFT),
        .OUT_W(OFF_W)
    ) u_pkt_scale (
        .base_i  (lba_i),
        .scaled_o(pkt_base)
    );

    assign offset_o   = (optical_i ? pkt_base : disk_base) + OFF_W'(index_i);
    assign raw_data_o = &lba_i;
endmodule

// File: rtl/dma_xfer_size.sv
module dma_xfer_size
    import dma_xfer_pkg::*;
#(
    parameter int SCNT_W = 8,
    parameter int SIZE_W = 20,
    parameter int REM_W  = 21
) (
    input  logic              optical_i,
    input  logic [SCNT_W-1:0] sector_cnt_i,
    input  logic [SIZE_W-1:0] packet_size_i,
    output logic [REM_W-1:0]  total_o
);
    logic [REM_W-1:0] disk_total;
    assign disk_total = REM_W'(sector_cnt_i) << DISK_SECTOR_SHIFT;
    assign total_o    = optical_i ? REM_W'(packet_size_i) : disk_total;
endmodule

// File: rtl/dma_xfer_decide.sv
module dma_xfer_decide
    import dma_xfer_pkg::*;
(
    input  logic    evt_chunk_i,
    input  logic    evt_result_i,
    input  logic    err_i,
    input  logic    active_i,
    input  logic    rem_nonpos_i,
    input  logic    len_zero_i,
    input  logic    optical_i,
    input  logic    raw_data_i,
    output action_e act_o
);
    always_comb begin
        if (!(evt_chunk_i || evt_result_i)) begin
            act_o = ACT_NONE;
        end else if (err_i) begin
            act_o = ACT_ERROR;
        end else if (!active_i) begin
            act_o = ACT_PARK;
        end else if (rem_nonpos_i) begin
            act_o = ACT_COMPLETE;
        end else if (len_zero_i) begin
            act_o = ACT_CHUNK_END;
        end else if (optical_i && raw_data_i) begin
            act_o = ACT_COPY;
        end else begin
            act_o = ACT_ISSUE;
        end
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_xfer_pkg::*;
#(
    parameter int SCNT_W = 8,
    parameter int SIZE_W = 20,
    parameter int SEC_W  = 24,
    parameter int LBA_W  = 20,
    parameter int LEN_W  = 16,
    localparam int DISK_SPAN = SEC_W + DISK_SECTOR_SHIFT,
    localparam int PKT_SPAN  = LBA_W + PKT_BLOCK_SHIFT,
    localparam int OFF_W     = ((DISK_SPAN > PKT_SPAN) ? DISK_SPAN : PKT_SPAN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_optical_i,
    input  logic [SCNT_W-1:0] sector_cnt_i,
    input  logic [SIZE_W-1:0] packet_size_i,
    input  logic [SEC_W-1:0]  cur_sector_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic [1:0]        cmd_i,
    input  logic              chunk_valid_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    input  logic              req_done_i,
    input  logic              req_err_i,
    output logic              kick_o,
    output logic              active_o,
    output logic              park_o,
    output logic              req_valid_o,
    output logic [1:0]        req_cmd_o,
    output logic [OFF_W-1:0]  req_offset_o,
    output logic [LEN_W-1:0]  req_len_o,
    output logic              copy_valid_o,
    output logic [LEN_W-1:0]  copy_len_o,
    output logic [2:0]        status_o,
    output logic              irq_o,
    output logic              dma_end_o,
    output logic              acct_ok_o,
    output logic              acct_fail_o
);
    localparam int DISK_TOT_W = SCNT_W + DISK_SECTOR_SHIFT;
    localparam int REM_W = ((DISK_TOT_W > SIZE_W) ? DISK_TOT_W : SIZE_W) + 1;
    localparam int IDX_W = REM_W;

    typedef struct packed {
        phase_e                   phase;
        logic                     active;
        logic                     opt;
        logic signed [REM_W-1:0]  rem;
        logic [IDX_W-1:0]         idx;
        drv_status_e              status;
        logic                     kick;
        logic                     park;
        logic                     req_valid;
        logic [1:0]               req_cmd;
        logic [OFF_W-1:0]         req_offset;
        logic [LEN_W-1:0]         req_len;
        logic                     copy_valid;
        logic [LEN_W-1:0]         copy_len;
        logic                     irq;
        logic                     dma_end;
        logic                     acct_ok;
        logic                     acct_fail;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic [REM_W-1:0]        total_w;
    logic [OFF_W-1:0]        offset_w;
    logic                    raw_w;
    logic                    evt_chunk_w;
    logic                    evt_result_w;
    logic                    rem_nonpos_w;
    logic                    counted_w;
    logic signed [REM_W-1:0] len_ext_w;
    logic [LEN_W-1:0]        copy_len_w;
    action_e                 act_w;

    dma_xfer_size #(
        .SCNT_W(SCNT_W),
        .SIZE_W(SIZE_W),
        .REM_W (REM_W)
    ) u_size (
        .optical_i    (is_optical_i),
        .sector_cnt_i (sector_cnt_i),
        .packet_size_i(packet_size_i),
        .total_o      (total_w)
    );

    dma_xfer_offset #(
        .SEC_W(SEC_W),
        .LBA_W(LBA_W),
        .IDX_W(IDX_W),
        .OFF_W(OFF_W)
    ) u_offset (
        .optical_i   (st_q.opt),
        .cur_sector_i(cur_sector_i),
        .lba_i       (lba_i),
        .index_i     (st_q.idx),
        .offset_o    (offset_w),
        .raw_data_o  (raw_w)
    );

    assign evt_chunk_w  = (st_q.phase == PH_IDLE) && chunk_valid_i;
    assign evt_result_w = (st_q.phase == PH_WAIT) && (req_done_i || req_err_i);
    assign rem_nonpos_w = st_q.rem[REM_W-1] || (st_q.rem == '0);
    assign counted_w    = st_q.opt || (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
    assign len_ext_w    = $signed({{(REM_W-LEN_W){1'b0}}, chunk_len_i});
    assign copy_len_w   = (st_q.rem < len_ext_w) ? st_q.rem[LEN_W-1:0] : chunk_len_i;

    dma_xfer_decide u_decide (
        .evt_chunk_i (evt_chunk_w),
        .evt_result_i(evt_result_w),
        .err_i       (evt_result_w && req_err_i),
        .active_i    (st_q.active),
        .rem_nonpos_i(rem_nonpos_w),
        .len_zero_i  (!evt_chunk_w || (chunk_len_i == '0)),
        .optical_i   (st_q.opt),
        .raw_data_i  (raw_w),
        .act_o       (act_w)
    );

    always_comb begin
        st_d            = st_q;
        st_d.kick       = 1'b0;
        st_d.park       = 1'b0;
        st_d.req_valid  = 1'b0;
        st_d.copy_valid = 1'b0;
        st_d.irq        = 1'b0;
        st_d.dma_end    = 1'b0;
        st_d.acct_ok    = 1'b0;
        st_d.acct_fail  = 1'b0;

        if (start_i) begin
            st_d.phase  = PH_IDLE;
            st_d.idx    = '0;
            st_d.rem    = $signed(total_w);
            st_d.active = 1'b1;
            st_d.opt    = is_optical_i;
            st_d.status = ST_NONE;
            st_d.kick   = 1'b1;
        end else begin
            case (act_w)
                ACT_PARK: begin
                    st_d.park  = 1'b1;
                    st_d.phase = PH_IDLE;
                end
                ACT_ERROR: begin
                    st_d.status    = st_q.opt ? ST_PKT_IOERR : ST_DMA_ERR;
                    st_d.irq       = 1'b1;
                    st_d.dma_end   = 1'b1;
                    st_d.acct_fail = counted_w;
                    st_d.active    = 1'b0;
                    st_d.phase     = PH_IDLE;
                end
                ACT_COMPLETE: begin
                    st_d.status  = st_q.opt ? ST_PKT_OK : ST_DISK_READY;
                    st_d.irq     = 1'b1;
                    st_d.dma_end = 1'b1;
                    st_d.acct_ok = counted_w;
                    st_d.active  = 1'b0;
                    st_d.phase   = PH_IDLE;
                end
                ACT_CHUNK_END: begin
                    st_d.dma_end = 1'b1;
                    st_d.acct_ok = counted_w;
                    st_d.phase   = PH_IDLE;
                end
                ACT_COPY: begin
                    st_d.copy_valid = 1'b1;
                    st_d.copy_len   = copy_len_w;
                    st_d.status     = ST_PKT_OK;
                    st_d.irq        = 1'b1;
                    st_d.dma_end    = 1'b1;
                    st_d.acct_ok    = 1'b1;
                    st_d.active     = 1'b0;
                    st_d.phase      = PH_IDLE;
                end
                ACT_ISSUE: begin
                    st_d.req_valid  = 1'b1;
                    st_d.req_cmd    = st_q.opt ? CMD_READ : cmd_i;
                    st_d.req_offset = offset_w;
                    st_d.req_len    = chunk_len_i;
                    st_d.idx        = st_q.idx + IDX_W'(chunk_len_i);
                    st_d.rem        = st_q.rem - len_ext_w;
                    st_d.phase      = PH_WAIT;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.phase  <= PH_IDLE;
            st_q.status <= ST_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign kick_o       = st_q.kick;
    assign active_o     = st_q.active;
    assign park_o       = st_q.park;
    assign req_valid_o  = st_q.req_valid;
    assign req_cmd_o    = st_q.req_cmd;
    assign req_offset_o = st_q.req_offset;
    assign req_len_o    = st_q.req_len;
    assign copy_valid_o = st_q.copy_valid;
    assign copy_len_o   = st_q.copy_len;
    assign status_o     = st_q.status;
    assign irq_o        = st_q.irq;
    assign dma_end_o    = st_q.dma_end;
    assign acct_ok_o    = st_q.acct_ok;
    assign acct_fail_o  = st_q.acct_fail;

    AST_KICK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> (active_o && status_o == ST_NONE && !dma_end_o)) // R1
        else $error("kick without armed transfer");

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        park_o |-> (!dma_end_o && !irq_o && !req_valid_o && !copy_valid_o)) // R2
        else $error("park with side effects");

    AST_IRQ_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!active_o && dma_end_o && status_o != ST_NONE)) // R3
        else $error("interrupt while still active");

    AST_CHUNK_END_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_end_o && !irq_o) |-> (active_o && $stable(status_o))) // R4
        else $error("chunk end changed transfer state");

    AST_REQ_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (active_o && !dma_end_o && req_len_o != '0)) // R5
        else $error("request outside active transfer");

    AST_COPY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid_o |-> (copy_len_o <= $past(chunk_len_i) && status_o == ST_PKT_OK)) // R7
        else $error("copy length above chunk length");

    AST_FAIL_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        acct_fail_o |-> (status_o == ST_DMA_ERR || status_o == ST_PKT_IOERR)) // R8
        else $error("failure pulse without error status");

    AST_ACCT_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (acct_ok_o || acct_fail_o) |-> (dma_end_o && !(acct_ok_o && acct_fail_o))) // R10
        else $error("statistics pulse off an end");

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o) // R11
        else $error("back-to-back requests");

endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_W = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_optical_i = 1'b0;
    logic [7:0]  sector_cnt_i = '0;
    logic [19:0] packet_size_i = '0;
    logic [23:0] cur_sector_i = '0;
    logic [19:0] lba_i = '0;
    logic [1:0]  cmd_i = '0;
    logic        chunk_valid_i = 1'b0;
    logic [15:0] chunk_len_i = '0;
    logic        req_done_i = 1'b0;
    logic        req_err_i = 1'b0;
    logic        kick_o, active_o, park_o, req_valid_o, copy_valid_o;
    logic        irq_o, dma_end_o, acct_ok_o, acct_fail_o;
    logic [1:0]  req_cmd_o;
    logic [OFF_W-1:0] req_offset_o;
    logic [15:0] req_len_o, copy_len_o;
    logic [2:0]  status_o;

    int n_checks = 0;
    int n_fail = 0;

    bit m_opt, m_active, m_busy;
    int m_rem, m_cmd;
    longint m_idx;
    logic [2:0] m_status;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_seq u_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_optical_i(is_optical_i),
        .sector_cnt_i(sector_cnt_i), .packet_size_i(packet_size_i),
        .cur_sector_i(cur_sector_i), .lba_i(lba_i), .cmd_i(cmd_i),
        .chunk_valid_i(chunk_valid_i), .chunk_len_i(chunk_len_i),
        .req_done_i(req_done_i), .req_err_i(req_err_i),
        .kick_o(kick_o), .active_o(active_o), .park_o(park_o),
        .req_valid_o(req_valid_o), .req_cmd_o(req_cmd_o), .req_offset_o(req_offset_o),
        .req_len_o(req_len_o), .copy_valid_o(copy_valid_o), .copy_len_o(copy_len_o),
        .status_o(status_o), .irq_o(irq_o), .dma_end_o(dma_end_o),
        .acct_ok_o(acct_ok_o), .acct_fail_o(acct_fail_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // vector order: kick park req copy irq end ok fail active
    function automatic longint outs();
        return {kick_o, park_o, req_valid_o, copy_valid_o, irq_o, dma_end_o,
                acct_ok_o, acct_fail_o, active_o};
    endfunction

    task automatic start_xfer(input bit opt, input int scnt, input int pkt, input int cmd);
        is_optical_i  = opt;
        sector_cnt_i  = scnt[7:0];
        packet_size_i = pkt[19:0];
        cmd_i         = cmd[1:0];
        start_i       = 1'b1;
        tick();
        start_i  = 1'b0;
        m_opt    = opt;
        m_cmd    = cmd;
        m_rem    = opt ? pkt : scnt * 512;
        m_idx    = 0;
        m_active = 1'b1;
        m_busy   = 1'b0;
        m_status = 3'd0;
        check("R1 start outputs", outs(), 9'b1_0000_0001);
        check("R1 start status", status_o, 0);
    endtask

    task automatic do_event(input bit is_chunk, input int len, input bit err, input string tag);
        bit e_park, e_req, e_copy, e_irq, e_end, e_ok, e_fail, counted;
        longint e_off;
        int e_copy_len;
        e_park = 0; e_req = 0; e_copy = 0; e_irq = 0; e_end = 0; e_ok = 0; e_fail = 0;
        e_off = 0; e_copy_len = 0;
        counted = m_opt || (m_cmd < 2);
        if (is_chunk) begin
            chunk_valid_i = 1'b1;
            chunk_len_i   = len[15:0];
        end else if (err) begin
            req_err_i = 1'b1;
        end else begin
            req_done_i = 1'b1;
        end
        tick();
        chunk_valid_i = 1'b0;
        req_done_i    = 1'b0;
        req_err_i     = 1'b0;
        if (is_chunk && m_busy) begin
            // ignored while a request is outstanding
        end else if (!is_chunk && err) begin
            m_status = m_opt ? 3'd4 : 3'd3;
            e_irq = 1; e_end = 1; e_fail = counted; m_active = 0; m_busy = 0;
        end else if (!m_active) begin
            e_park = 1; m_busy = 0;
        end else if (m_rem <= 0) begin
            m_status = m_opt ? 3'd2 : 3'd1;
            e_irq = 1; e_end = 1; e_ok = counted; m_active = 0; m_busy = 0;
        end else if (!is_chunk || len == 0) begin
            e_end = 1; e_ok = counted; m_busy = 0;
        end else if (m_opt && lba_i == 20'hFFFFF) begin
            e_copy = 1;
            e_copy_len = (m_rem < len) ? m_rem : len;
            m_status = 3'd2;
            e_irq = 1; e_end = 1; e_ok = 1; m_active = 0;
        end else begin
            e_req = 1;
            e_off = m_opt ? (longint'(lba_i) * 2048 + m_idx)
                          : (longint'(cur_sector_i) * 512 + m_idx);
            m_idx = m_idx + len;
            m_rem = m_rem - len;
            m_busy = 1;
        end
        check(tag, outs(), {1'b0, e_park, e_req, e_copy, e_irq, e_end, e_ok, e_fail, m_active});
        check(tag, status_o, m_status);
        if (e_req) begin
            check(tag, req_offset_o, e_off);
            check(tag, req_len_o, len);
            check(tag, req_cmd_o, m_opt ? 0 : m_cmd);
        end
        if (e_copy) check(tag, copy_len_o, e_copy_len);
    endtask

    task automatic run_to_end(input int len, input string tag);
        while (m_active) begin
            do_event(1'b1, len, 1'b0, tag);
            if (m_busy) do_event(1'b0, 0, 1'b0, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        m_opt = 0; m_active = 0; m_busy = 0; m_rem = 0; m_cmd = 0; m_idx = 0; m_status = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", outs(), 0);
        check("R1 reset status", status_o, 0);

        // R2: chunk before any start parks
        do_event(1'b1, 512, 1'b0, "R2 park before start");

        // R5 R9 R10 R3: disk sweep over commands, sizes, sectors, chunk sizes
        for (int c = 0; c < 3; c++) begin
            for (int s = 1; s <= 3; s++) begin
                for (int k = 0; k < 3; k++) begin
                    cur_sector_i = (k == 0) ? 24'd0 : (k == 1) ? 24'd5 : 24'hFFFFF0;
                    start_xfer(1'b0, s, 0, c);
                    run_to_end((c == 0) ? 512 : (c == 1) ? 384 : 1024, "R5 R9 R10 disk sweep");
                    do_event(1'b1, 512, 1'b0, "R2 park after end");
                end
            end
        end

        // R3: zero size completes at the first chunk
        start_xfer(1'b0, 0, 0, 0);
        do_event(1'b1, 512, 1'b0, "R3 empty disk");

        // R4: zero length chunk mid transfer
        cur_sector_i = 24'd7;
        start_xfer(1'b0, 2, 0, 1);
        do_event(1'b1, 512, 1'b0, "R5 first chunk");
        // R11: chunk while request outstanding is ignored
        do_event(1'b1, 100, 1'b0, "R11 busy chunk");
        do_event(1'b0, 0, 1'b0, "R9 chunk result");
        do_event(1'b1, 0, 1'b0, "R4 zero chunk");
        run_to_end(512, "R9 finish");

        // R8: disk error, disk trim error, optical error
        start_xfer(1'b0, 4, 0, 0);
        do_event(1'b1, 512, 1'b0, "R5 pre error");
        do_event(1'b0, 0, 1'b1, "R8 disk error");
        start_xfer(1'b0, 4, 0, 2);
        do_event(1'b1, 512, 1'b0, "R5 pre trim error");
        do_event(1'b0, 0, 1'b1, "R8 R10 trim error");
        lba_i = 20'd9;
        start_xfer(1'b1, 0, 4096, 0);
        do_event(1'b1, 2048, 1'b0, "R6 pre error");
        do_event(1'b0, 0, 1'b1, "R8 optical error");

        // R6 R3: optical sweep
        for (int a = 0; a < 3; a++) begin
            for (int p = 0; p < 2; p++) begin
                lba_i = (a == 0) ? 20'd0 : (a == 1) ? 20'd3 : 20'hFFFFE;
                start_xfer(1'b1, 0, (p == 0) ? 2048 : 5000, 1);
                run_to_end(2048, "R6 R3 optical sweep");
            end
        end

        // R7: raw packet data copy, both orderings
        lba_i = 20'hFFFFF;
        start_xfer(1'b1, 0, 100, 0);
        do_event(1'b1, 64, 1'b0, "R7 copy chunk shorter");
        start_xfer(1'b1, 0, 50, 0);
        do_event(1'b1, 64, 1'b0, "R7 copy remaining shorter");
        do_event(1'b1, 64, 1'b0, "R2 park after copy");

        report();
    end
endmodule